// File: doc/BRIEF.md
# Guard Timer

The guard timer is a 32-bit down-counter behind a single-cycle register bus. It has two personalities. As a plain interval timer it raises a level interrupt each time the count runs out. As a watchdog it emits a one-cycle reset request instead, and it records the event in a sticky status flag. Software keeps a watchdog alive by rewriting the load register before the count runs out. An 8-bit prescale divider sets the count rate.

Once the watchdog personality is switched on, an ordinary control write cannot switch it off. The only way back to timer mode is a two-word key written to a dedicated disarm register. A small state machine tracks that key. In state `UNL_IDLE`, a write of the first key word to the disarm register takes the transition `IDLE->ARMED`. In state `UNL_ARMED`, the next bus write decides the outcome. If it is the second key word written to the disarm register, the transition is `ARMED->IDLE (clear)` and the watchdog bit is cleared. Any other write takes `ARMED->IDLE (abort)`. Reads never move the state machine.

Word addresses: 0 load, 1 count (read-only), 2 control, 3 interrupt status, 4 reset status, 5 disarm. Every register reads back 0 in bits that are not assigned. The disarm register always reads 0.

Top module: `guard_timer`

## Requirements
- R1: After reset, every register reads 0, and `irq_o` and `wd_reset_o` are low.
- R2: The control word (address 2) places enable in bit 0, watchdog select in bit 3 and the prescale value in bits 15:8. It reads back from those positions.
- R3: A write to load (address 0) sets the load register and the counter to the written value. The counter reads at address 1. While enable is 0, the counter holds its value.
- R4: A write to load or to control restarts the prescaler. The counter then steps once every prescale+1 cycles. An expiry occurs on a step taken while the counter is 0, and that step reloads the counter from the load register. With enable set at edge E, load N and prescale P, the first expiry falls on edge E+(N+1)(P+1).
- R5: An expiry in timer mode sets interrupt status bit 0. `irq_o` is that bit, active high and level.
- R6: Writing 1 to bit 0 of interrupt status (address 3) clears it. Writing 0 leaves it unchanged.
- R7: An expiry in watchdog mode drives `wd_reset_o` high for exactly one cycle and sets reset status bit 0 (address 4). It does not set interrupt status. The flag stays set after the pulse and clears only when 1 is written to bit 0.
- R8: A control write with bit 3 at 0 leaves an active watchdog bit set, while the other fields still take the written values. A control write with bit 3 at 1 always sets the watchdog bit.
- R9: Writing 0x12345678 and then 0x87654321 to disarm (address 5), with no other write in between, clears the watchdog bit on the edge of the second write.
- R10: The key sequence aborts on any other write after the first word, including a wrong second word. A later second word alone then has no effect.
- R11: After the watchdog bit has been cleared, a control write of 0 stops the block. The counter holds its value and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Word address of the register accessed |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Timer-mode expiry interrupt, level |
| wd_reset_o | output | 1 | Watchdog-mode expiry reset request, one-cycle pulse |

## Verification
The assertions assume that a bus write lasts one cycle with stable address and data, and that nothing drives the bus during reset. The bench changes the bus only on falling edges and holds `bus_we` for exactly one rising edge per write. In the random phase the enable bit is always written as 0. This keeps the counter still, so any change in the watchdog bit or the prescale field can only come from the write sequence, which the bench mirrors in its own model of the key tracker.

// File: rtl/guard_pkg.sv
package guard_pkg;
    localparam int GT_DATA_W  = 32;
    localparam int GT_ADDR_W  = 3;
    localparam int GT_PRESC_W = 8;

    localparam logic [GT_ADDR_W-1:0] OFS_LOAD   = 3'd0;
    localparam logic [GT_ADDR_W-1:0] OFS_COUNT  = 3'd1;
    localparam logic [GT_ADDR_W-1:0] OFS_CTRL   = 3'd2;
    localparam logic [GT_ADDR_W-1:0] OFS_IRQ    = 3'd3;
    localparam logic [GT_ADDR_W-1:0] OFS_RST    = 3'd4;
    localparam logic [GT_ADDR_W-1:0] OFS_DISARM = 3'd5;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_WD_BIT  = 3;
    localparam int CTRL_PRE_LSB = 8;

    localparam logic [GT_DATA_W-1:0] KEY_FIRST  = 32'h1234_5678;
    localparam logic [GT_DATA_W-1:0] KEY_SECOND = 32'h8765_4321;

    typedef enum logic [0:0] {
        UNL_IDLE  = 1'b0,
        UNL_ARMED = 1'b1
    } unlock_state_t;
endpackage

// File: rtl/guard_prescale.sv
module guard_prescale #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               restart_i,
    input  logic [PRESC_W-1:0] div_i,
    output logic               tick_o
);
    logic [PRESC_W-1:0] phase_q;
    logic               wrap;

    assign wrap   = (phase_q == div_i);
    assign tick_o = run_i && !restart_i && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart_i || !run_i || wrap) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/guard_count.sv
module guard_count #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_wr_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic [DATA_W-1:0] reload_i,
    input  logic              step_i,
    output logic [DATA_W-1:0] count_o,
    output logic              expire_o
);
    logic [DATA_W-1:0] cnt_q;
    logic              at_zero;

    assign at_zero  = (cnt_q == '0);
    assign expire_o = step_i && !load_wr_i && at_zero;
    assign count_o  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_wr_i) begin
            cnt_q <= load_val_i;
        end else if (step_i) begin
            cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/guard_unlock.sv
module guard_unlock
    import guard_pkg::*;
#(
    parameter int                 DATA_W   = 32,
    parameter int                 ADDR_W   = 3,
    parameter logic [ADDR_W-1:0]  KEY_ADDR = 3'd5,
    parameter logic [DATA_W-1:0]  KEY_A    = 32'h1234_5678,
    parameter logic [DATA_W-1:0]  KEY_B    = 32'h8765_4321
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              clear_o
);
    unlock_state_t state_q, state_d;
    logic          hit_a, hit_b;

    assign hit_a = wr_i && (addr_i == KEY_ADDR) && (data_i == KEY_A);
    assign hit_b = wr_i && (addr_i == KEY_ADDR) && (data_i == KEY_B);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= UNL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UNL_IDLE:  if (hit_a) state_d = UNL_ARMED;
            UNL_ARMED: if (wr_i)  state_d = UNL_IDLE;
            default:   state_d = UNL_IDLE;
        endcase
    end

    always_comb begin
        clear_o = 1'b0;
        unique case (state_q)
            UNL_IDLE:  clear_o = 1'b0;
            UNL_ARMED: clear_o = hit_b;
            default:   clear_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import guard_pkg::*;
#(
    parameter int DATA_W  = GT_DATA_W,
    parameter int ADDR_W  = GT_ADDR_W,
    parameter int PRESC_W = GT_PRESC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              wd_reset_o
);
    localparam int PRE_MSB = CTRL_PRE_LSB + PRESC_W - 1;

    logic               wr_load, wr_ctrl, wr_irq, wr_rst;
    logic [DATA_W-1:0]  load_q;
    logic               en_q, wd_q, irq_q, rflag_q, pulse_q;
    logic [PRESC_W-1:0] presc_q;
    logic               tick, expire, unlock_clr;
    logic [DATA_W-1:0]  count_w;
    logic [DATA_W-1:0]  ctrl_view;

    assign wr_load = bus_we && (bus_addr == OFS_LOAD);
    assign wr_ctrl = bus_we && (bus_addr == OFS_CTRL);
    assign wr_irq  = bus_we && (bus_addr == OFS_IRQ);
    assign wr_rst  = bus_we && (bus_addr == OFS_RST);

    guard_prescale #(.PRESC_W(PRESC_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (en_q),
        .restart_i (wr_load || wr_ctrl),
        .div_i     (presc_q),
        .tick_o    (tick)
    );

    guard_count #(.DATA_W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_wr_i  (wr_load),
        .load_val_i (bus_wdata),
        .reload_i   (load_q),
        .step_i     (tick),
        .count_o    (count_w),
        .expire_o   (expire)
    );

    guard_unlock #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .KEY_ADDR (OFS_DISARM),
        .KEY_A    (KEY_FIRST),
        .KEY_B    (KEY_SECOND)
    ) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_we),
        .addr_i  (bus_addr),
        .data_i  (bus_wdata),
        .clear_o (unlock_clr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q  <= '0;
            en_q    <= 1'b0;
            presc_q <= '0;
        end else begin
            if (wr_load) load_q <= bus_wdata;
            if (wr_ctrl) begin
                en_q    <= bus_wdata[CTRL_EN_BIT];
                presc_q <= bus_wdata[PRE_MSB:CTRL_PRE_LSB];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_q <= 1'b0;
        end else if (unlock_clr) begin
            wd_q <= 1'b0;
        end else if (wr_ctrl && bus_wdata[CTRL_WD_BIT]) begin
            wd_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q   <= 1'b0;
            rflag_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= expire && wd_q;
            if (expire && !wd_q)             irq_q <= 1'b1;
            else if (wr_irq && bus_wdata[0]) irq_q <= 1'b0;
            if (expire && wd_q)              rflag_q <= 1'b1;
            else if (wr_rst && bus_wdata[0]) rflag_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_view = '0;
        ctrl_view[CTRL_EN_BIT] = en_q;
        ctrl_view[CTRL_WD_BIT] = wd_q;
        ctrl_view[PRE_MSB:CTRL_PRE_LSB] = presc_q;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_LOAD:  bus_rdata = load_q;
            OFS_COUNT: bus_rdata = count_w;
            OFS_CTRL:  bus_rdata = ctrl_view;
            OFS_IRQ:   bus_rdata[0] = irq_q;
            OFS_RST:   bus_rdata[0] = rflag_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_o      = irq_q;
    assign wd_reset_o = pulse_q;
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk
    import guard_pkg::*;
#(
    parameter int DATA_W = GT_DATA_W,
    parameter int ADDR_W = GT_ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_o,
    input logic              wd_reset_o,
    input logic              en_q,
    input logic              wd_q,
    input logic              rflag_q,
    input logic [DATA_W-1:0] count_w
);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !(bus_we && bus_addr == OFS_LOAD)) |=> $stable(count_w));

    assert_irq_timer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> !$past(wd_q));

    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(bus_we && bus_addr == OFS_IRQ && bus_wdata[0]));

    assert_pulse_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset_o |=> !wd_reset_o);

    assert_pulse_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset_o |-> (rflag_q && $past(wd_q)));

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rflag_q) |-> $past(bus_we && bus_addr == OFS_RST && bus_wdata[0]));

    assert_wd_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_q) |-> $past(bus_we && bus_addr == OFS_DISARM && bus_wdata == KEY_SECOND));

    assert_wd_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_q && !(bus_we && bus_addr == OFS_DISARM)) |=> wd_q);
endmodule

bind guard_timer guard_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .irq_o      (irq_o),
    .wd_reset_o (wd_reset_o),
    .en_q       (en_q),
    .wd_q       (wd_q),
    .rflag_q    (rflag_q),
    .count_w    (count_w)
);

// File: tb/guard_timer_test.sv
module guard_timer_test;
    localparam logic [2:0] A_LOAD = 3'd0, A_CNT = 3'd1, A_CTRL = 3'd2,
                           A_IRQ = 3'd3, A_RST = 3'd4, A_DIS = 3'd5;
    localparam logic [31:0] K1 = 32'h1234_5678, K2 = 32'h8765_4321;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, wd_reset_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    guard_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wd_reset_o(wd_reset_o)
    );

    always #2 clk = ~clk;

    function automatic int unsigned expiry_edges(int unsigned n, int unsigned p);
        return (n + 1) * (p + 1);
    endfunction

    function automatic logic [31:0] ctrl_word(logic en, logic wd, logic [7:0] p);
        return {16'h0, p, 4'h0, wd, 2'b00, en};
    endfunction

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, got %0d cycles, expected fewer", cycles);
            finish_up();
        end
    end

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic peek(logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_neg(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    logic [31:0] v, v2;
    int unsigned k;
    logic        m_wd, m_armed;
    logic [7:0]  m_pre;

    initial begin
        wait_neg(4);
        rst_n = 1'b1;
        wait_neg(1);
        // R1 reset state
        chk("R1 irq_o", {31'h0, irq_o}, 0);
        chk("R1 wd_reset_o", {31'h0, wd_reset_o}, 0);
        for (int a = 0; a < 6; a++) begin
            peek(a[2:0], v);
            chk("R1 register", v, 0);
        end

        // R2 R3 field readback and hold while disabled
        wr(A_CTRL, ctrl_word(1'b0, 1'b0, 8'd3));
        peek(A_CTRL, v); chk("R2 control readback", v, 32'h0000_0300);
        wr(A_LOAD, 32'd100);
        peek(A_CNT, v); chk("R3 counter loaded", v, 100);
        peek(A_LOAD, v); chk("R3 load readback", v, 100);
        wait_neg(20);
        peek(A_CNT, v); chk("R3 counter holds while disabled", v, 100);

        // R4 R5 timer expiry, prescale 3, load 4
        wr(A_LOAD, 32'd4);
        wr(A_CTRL, ctrl_word(1'b1, 1'b0, 8'd3));
        k = expiry_edges(4, 3);
        peek(A_CNT, v); chk("R4 count at enable", v, 4);
        wait_neg(4);
        peek(A_CNT, v); chk("R4 one step after P+1 cycles", v, 3);
        wait_neg(int'(k) - 1 - 4);
        chk("R4 no expiry before period", {31'h0, irq_o}, 0);
        wait_neg(1);
        chk("R5 irq_o after expiry", {31'h0, irq_o}, 1);
        peek(A_IRQ, v); chk("R5 interrupt status", v, 1);
        peek(A_CNT, v); chk("R4 reload on expiry", v, 4);
        chk("R5 no reset pulse in timer mode", {31'h0, wd_reset_o}, 0);

        // R6 write-1-to-clear
        wr(A_IRQ, 32'h0);
        chk("R6 write 0 keeps irq", {31'h0, irq_o}, 1);
        wr(A_CTRL, ctrl_word(1'b0, 1'b0, 8'd3));
        wr(A_IRQ, 32'h1);
        chk("R6 write 1 clears irq", {31'h0, irq_o}, 0);

        // R4 corner: prescale 0, load 2
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, ctrl_word(1'b1, 1'b0, 8'd0));
        k = expiry_edges(2, 0);
        wait_neg(int'(k) - 1);
        chk("R4 prescale 0 before expiry", {31'h0, irq_o}, 0);
        wait_neg(1);
        chk("R4 prescale 0 expiry", {31'h0, irq_o}, 1);
        wr(A_CTRL, 32'h0);
        wr(A_IRQ, 32'h1);

        // R7 watchdog expiry
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, ctrl_word(1'b1, 1'b1, 8'd3));
        k = expiry_edges(2, 3);
        wait_neg(int'(k) - 1);
        chk("R7 no pulse before period", {31'h0, wd_reset_o}, 0);
        peek(A_RST, v); chk("R7 flag clear before period", v, 0);
        wait_neg(1);
        chk("R7 reset pulse", {31'h0, wd_reset_o}, 1);
        peek(A_RST, v); chk("R7 reset flag set", v, 1);
        wait_neg(1);
        chk("R7 pulse lasts one cycle", {31'h0, wd_reset_o}, 0);
        chk("R7 no irq in watchdog mode", {31'h0, irq_o}, 0);
        peek(A_RST, v); chk("R7 flag persists", v, 1);

        // R8 sticky watchdog bit
        wr(A_CTRL, ctrl_word(1'b0, 1'b0, 8'd2));
        peek(A_CTRL, v); chk("R8 wd bit kept, other fields taken", v, 32'h0000_0208);
        wr(A_RST, 32'h0);
        peek(A_RST, v); chk("R7 write 0 keeps flag", v, 1);
        wr(A_RST, 32'h1);
        peek(A_RST, v); chk("R7 write 1 clears flag", v, 0);

        // R10 aborted sequences
        wr(A_DIS, K1); wr(A_LOAD, 32'd5); wr(A_DIS, K2);
        peek(A_CTRL, v); chk("R10 intervening write aborts", v[3], 1);
        wr(A_DIS, K1); wr(A_DIS, 32'hDEAD_BEEF); wr(A_DIS, K2);
        peek(A_CTRL, v); chk("R10 wrong second word aborts", v[3], 1);

        // R9 good sequence
        wr(A_DIS, K1); wr(A_DIS, K2);
        peek(A_CTRL, v); chk("R9 key clears watchdog bit", v, 32'h0000_0200);
        peek(A_DIS, v); chk("R9 disarm reads zero", v, 0);

        // R11 full stop
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, ctrl_word(1'b1, 1'b0, 8'd0));
        wr(A_CTRL, 32'h0);
        peek(A_CTRL, v); chk("R11 control zero", v, 0);
        peek(A_CNT, v);
        wait_neg(30);
        peek(A_CNT, v2); chk("R11 counter frozen", v2, v);
        chk("R11 no expiry when stopped", {31'h0, irq_o}, 0);

        // random phase: R2 R8 R9 R10 against a model of the key tracker
        void'($urandom(32'h0000_5EED));
        m_wd = 1'b0; m_armed = 1'b0; m_pre = 8'h00;
        for (int it = 0; it < 400; it++) begin
            logic [31:0] d;
            logic [2:0]  a;
            int          op;
            op = int'($urandom % 5);
            d  = $urandom;
            case (op)
                0: begin a = A_CTRL; d[0] = 1'b0; end
                1: begin a = A_DIS; d = K1; end
                2: begin a = A_DIS; d = K2; end
                3: a = A_DIS;
                default: a = A_LOAD;
            endcase
            if (m_armed && a == A_DIS && d == K2) m_wd = 1'b0;
            m_armed = !m_armed && a == A_DIS && d == K1;
            if (a == A_CTRL) begin
                m_pre = d[15:8];
                if (d[3]) m_wd = 1'b1;
            end
            wr(a, d);
            peek(A_CTRL, v);
            chk("R8 R9 R10 random control state", v, ctrl_word(1'b0, m_wd, m_pre));
        end

        finish_up();
    end
endmodule